// File: doc/BRIEF.md
# Iterative Floating-Point Divider and Square-Root Unit

This block computes the quotient of two normalized floating-point operands, or the square root of one, by restoring digit recurrence. It produces one result bit per clock. Both operations run through a single remainder register and a single subtractor. A mode input chooses how that subtractor is fed: the divisor for division, or the partial root with a trailing `01` for square root. Operands arrive split into sign, a two-bit class, an unbiased exponent and a 53-bit significand with the hidden one at bit 52. Single-precision operands use the same 53-bit field with the low 29 bits zero. The result is returned unrounded: a right-aligned block of result bits, an exponent and a sticky bit. A later stage rounds and packs it.

A one-cycle `start` in idle latches the operands and the mode. `busy` then stays high for the whole run, and `done` pulses once when the result registers are valid. The result registers hold their values until the next completion. Special operands follow the same fixed timing. For these the unit reports zero, infinity or a canonical NaN through dedicated outputs and raises invalid or divide-by-zero where it applies. Only the slow bit-serial mode is provided.

Top module: `fp_divsqrt_iter`

## Requirements
- R1: A `start` accepted in idle is followed by a one-cycle `done` exactly L clock edges after the accepting edge. L is 29 for single division, 28 for single square root, 58 for double division and 57 for double square root. `is_sqrt`=1 selects square root and `is_dp`=1 selects double.
- R2: `busy` is high from the accepting edge until the edge that raises `done`. `busy` and `done` are never high together, and `done` lasts a single cycle.
- R3: A `start` seen while `busy` is high is ignored, and so is any change of the operand inputs after acceptance. The run in progress keeps its timing and its result, and no extra `done` follows.
- R4: For normal division operands, `res_man` equals floor(ma·2^(N-1)/mb), with N = 28 for single and 57 for double. `res_exp` equals ea−eb, and `res_sign` is the XOR of the operand signs.
- R5: For a normal positive square-root operand, let M = ma, or 2·ma when ea is odd. `res_man` equals floor(sqrt(M·2^(2N−54))), with N = 27 for single and 56 for double. `res_exp` equals floor(ea/2), and `res_sign` is 0.
- R6: For a normal result, `res_sticky` is 1 exactly when the final remainder is nonzero, which means the exact result has further nonzero bits.
- R7: A normal dividend over a zero divisor gives an infinite result with `flag_dz` set and the XOR sign.
- R8: 0/0, inf/inf and the square root of any negative nonzero value give a NaN with `flag_nv` set. Every NaN result is canonical: sign 0, exponent 0, sticky 0, and only bit 55 of `res_man` set.
- R9: A NaN operand (class 3) gives the canonical NaN with neither flag raised.
- R10: The square root of −0 gives −0, the square root of +0 gives +0 and the square root of +inf gives +inf, all with no flags.
- R11: In division, inf over a normal or zero operand gives infinity, and no divide-by-zero flag is raised for inf/0. A zero dividend, or an infinite divisor with a normal or zero dividend, gives zero. Special results have exponent 0, sticky 0 and zero significand apart from the NaN pattern, and at most one of `res_zero`, `res_inf`, `res_nan` is set. Class codes: 0 normal, 1 zero, 2 infinity, 3 NaN.
- R12: While `rst_n` is low at a clock edge, the unit returns to idle and clears `busy`, `done`, the flags and the result kind outputs. An operation cut off this way never signals `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch request, accepted only in idle |
| is_sqrt | input | 1 | 1 = square root, 0 = division |
| is_dp | input | 1 | 1 = double precision timing, 0 = single |
| a_sign | input | 1 | Dividend / radicand sign |
| a_class | input | 2 | Dividend / radicand class (0 normal, 1 zero, 2 inf, 3 NaN) |
| a_exp | input | 13 | Dividend / radicand unbiased exponent, two's complement |
| a_man | input | 53 | Dividend / radicand significand, hidden one at bit 52 |
| b_sign | input | 1 | Divisor sign |
| b_class | input | 2 | Divisor class |
| b_exp | input | 13 | Divisor unbiased exponent |
| b_man | input | 53 | Divisor significand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_sign | output | 1 | Result sign |
| res_exp | output | 14 | Result unbiased exponent, two's complement |
| res_man | output | 57 | Right-aligned unrounded result bits |
| res_sticky | output | 1 | Nonzero final remainder |
| res_zero | output | 1 | Result is zero |
| res_inf | output | 1 | Result is infinite |
| res_nan | output | 1 | Result is the canonical NaN |
| flag_nv | output | 1 | Invalid operation |
| flag_dz | output | 1 | Divide by zero |

## Verification
The hardest case to bring about from the ports is a second `start` that lands in the middle of a run while the operand and mode inputs also change. Only correct latching at acceptance keeps the first result intact. The stimulus raises `start` on the fifth busy cycle with the other mode, double timing and different operands. It then checks that completion still comes at the first operation's latency with the first operation's quotient, and that no second `done` appears. Odd exponents, including negative ones, are covered so that the radicand pre-shift and the floor of the halved exponent are both exercised. A reset asserted mid-run completes the picture.

// File: rtl/dsq_pkg.sv
// Shared types for the iterative divide / square-root unit.
// Assumes operand classification is done upstream and delivered as fcls_e.
package dsq_pkg;

    typedef enum logic [1:0] {
        CLS_NORM = 2'b00,
        CLS_ZERO = 2'b01,
        CLS_INF  = 2'b10,
        CLS_NAN  = 2'b11
    } fcls_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ITER = 2'b01,
        ST_FIN  = 2'b10
    } dsq_state_e;

    // Outcome of the special-operand screen, latched at acceptance.
    typedef struct packed {
        logic  hit;
        fcls_e kind;
        logic  sign;
        logic  nv;
        logic  dz;
    } spec_t;

endpackage

// File: rtl/dsq_ctrl.sv
// Sequencer for the iterative divide / square-root unit.
// Accepts start only in idle. It runs (latency-1) recurrence steps, then one
// finish cycle, so done rises a fixed number of edges after acceptance.
// Assumes every latency parameter is at least 2.
module dsq_ctrl
    import dsq_pkg::*;
#(
    parameter int SP_DIV_LAT  = 29,
    parameter int SP_SQRT_LAT = 28,
    parameter int DP_DIV_LAT  = 58,
    parameter int DP_SQRT_LAT = 57
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_sqrt,
    input  logic is_dp,
    output logic busy,
    output logic load,
    output logic step,
    output logic finish,
    output logic done
);

    localparam int MAX_SP  = (SP_DIV_LAT > SP_SQRT_LAT) ? SP_DIV_LAT : SP_SQRT_LAT;
    localparam int MAX_DP  = (DP_DIV_LAT > DP_SQRT_LAT) ? DP_DIV_LAT : DP_SQRT_LAT;
    localparam int MAX_LAT = (MAX_SP > MAX_DP) ? MAX_SP : MAX_DP;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    dsq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lat_sel;

    // Pick the total latency for the requested mode and precision.
    always_comb begin
        unique case ({is_dp, is_sqrt})
            2'b00:   lat_sel = CNT_W'(SP_DIV_LAT);
            2'b01:   lat_sel = CNT_W'(SP_SQRT_LAT);
            2'b10:   lat_sel = CNT_W'(DP_DIV_LAT);
            default: lat_sel = CNT_W'(DP_SQRT_LAT);
        endcase
    end

    assign busy   = (state != ST_IDLE);
    assign load   = start && (state == ST_IDLE);
    assign step   = (state == ST_ITER);
    assign finish = (state == ST_FIN);

    // State, step counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    state <= ST_ITER;
                    cnt   <= lat_sel - 1'b1;
                end
                ST_ITER: begin
                    cnt <= cnt - 1'b1;
                    if (cnt == CNT_W'(1)) state <= ST_FIN;
                end
                ST_FIN: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Independent latency monitor used only by the checks below.
    logic [CNT_W-1:0] mon_cnt;
    logic [CNT_W-1:0] mon_lat;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_cnt <= '0;
            mon_lat <= '0;
        end else if (load) begin
            mon_cnt <= '0;
            mon_lat <= lat_sel;
        end else if (busy) begin
            mon_cnt <= mon_cnt + 1'b1;
        end
    end

    // R1
    latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mon_cnt == mon_lat));

    // R2
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ITER && cnt > CNT_W'(1)) |=>
            (state == ST_ITER && cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/dsq_special.sv
// Special-operand screen for divide and square root.
// Purely combinational. It decides whether the result bypasses the
// recurrence and, if so, its kind, sign and exception flags.
// Assumes class codes are valid fcls_e values.
module dsq_special
    import dsq_pkg::*;
(
    input  logic  is_sqrt,
    input  logic  a_sign,
    input  fcls_e a_cls,
    input  logic  b_sign,
    input  fcls_e b_cls,
    output spec_t spec
);

    logic q_sign;
    assign q_sign = a_sign ^ b_sign;

    // Priority decision: NaN in, invalid forms, infinities, zeros, normal.
    always_comb begin
        spec = '{hit: 1'b1, kind: CLS_NAN, sign: 1'b0, nv: 1'b0, dz: 1'b0};
        if (is_sqrt) begin
            if (a_cls == CLS_NAN) begin
                spec.kind = CLS_NAN;
            end else if (a_cls == CLS_ZERO) begin
                spec.kind = CLS_ZERO;
                spec.sign = a_sign;
            end else if (a_sign) begin
                spec.kind = CLS_NAN;
                spec.nv   = 1'b1;
            end else if (a_cls == CLS_INF) begin
                spec.kind = CLS_INF;
            end else begin
                spec.hit  = 1'b0;
                spec.kind = CLS_NORM;
            end
        end else begin
            if (a_cls == CLS_NAN || b_cls == CLS_NAN) begin
                spec.kind = CLS_NAN;
            end else if ((a_cls == CLS_ZERO && b_cls == CLS_ZERO) ||
                         (a_cls == CLS_INF  && b_cls == CLS_INF)) begin
                spec.kind = CLS_NAN;
                spec.nv   = 1'b1;
            end else if (b_cls == CLS_ZERO) begin
                spec.kind = CLS_INF;
                spec.sign = q_sign;
                spec.dz   = (a_cls == CLS_NORM);
            end else if (a_cls == CLS_INF) begin
                spec.kind = CLS_INF;
                spec.sign = q_sign;
            end else if (a_cls == CLS_ZERO || b_cls == CLS_INF) begin
                spec.kind = CLS_ZERO;
                spec.sign = q_sign;
            end else begin
                spec.hit  = 1'b0;
                spec.kind = CLS_NORM;
                spec.sign = q_sign;
            end
        end
    end

endmodule

// File: rtl/dsq_recur.sv
// Shared restoring recurrence for divide and square root.
// One subtractor serves both modes and retires one result bit per step.
// Division compares the remainder against the divisor. Square root brings
// down two radicand bits and compares against (root << 2) | 1.
// Assumes normalized significands (top bit set) and RES_W + 3 remainder bits.
module dsq_recur #(
    parameter  int MAN_W = 53,
    parameter  int EXP_W = 13,
    parameter  int RES_W = 57,
    localparam int REM_W = RES_W + 3,
    localparam int RAD_W = MAN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             is_sqrt,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [MAN_W-1:0] a_man,
    input  logic [MAN_W-1:0] b_man,
    output logic [RES_W-1:0] quo,
    output logic             rem_nz,
    output logic [EXP_W:0]   exp_res
);

    logic             sqrt_q;
    logic [REM_W-1:0] rem;
    logic [RES_W-1:0] qr;
    logic [RAD_W-1:0] opnd;
    logic [EXP_W:0]   exp_q;

    logic [REM_W-1:0] lhs, rhs, kept;
    logic [REM_W:0]   diff;
    logic             bit_ok;

    // Mode-specific operand steering into the shared subtractor.
    always_comb begin
        if (sqrt_q) begin
            lhs = {rem[REM_W-3:0], opnd[RAD_W-1:RAD_W-2]};
            rhs = REM_W'({qr, 2'b01});
        end else begin
            lhs = rem;
            rhs = REM_W'(opnd);
        end
        diff   = {1'b0, lhs} - {1'b0, rhs};
        bit_ok = ~diff[REM_W];
        kept   = bit_ok ? diff[REM_W-1:0] : lhs;
    end

    // Operand latch on acceptance and one recurrence step per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sqrt_q <= 1'b0;
            rem    <= '0;
            qr     <= '0;
            opnd   <= '0;
            exp_q  <= '0;
        end else if (load) begin
            sqrt_q <= is_sqrt;
            qr     <= '0;
            if (is_sqrt) begin
                rem   <= '0;
                opnd  <= a_exp[0] ? {a_man, 1'b0} : {1'b0, a_man};
                exp_q <= {a_exp[EXP_W-1], a_exp[EXP_W-1], a_exp[EXP_W-1:1]};
            end else begin
                rem   <= REM_W'(a_man);
                opnd  <= {1'b0, b_man};
                exp_q <= {a_exp[EXP_W-1], a_exp} - {b_exp[EXP_W-1], b_exp};
            end
        end else if (step) begin
            qr <= {qr[RES_W-2:0], bit_ok};
            if (sqrt_q) begin
                rem  <= kept;
                opnd <= {opnd[RAD_W-3:0], 2'b00};
            end else begin
                rem  <= {kept[REM_W-2:0], 1'b0};
            end
        end
    end

    assign quo     = qr;
    assign rem_nz  = |rem;
    assign exp_res = exp_q;

    // R4
    div_rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !sqrt_q) |-> (rem < REM_W'({opnd, 1'b0})));

    // R5
    sqrt_rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && sqrt_q) |-> (rem <= REM_W'({qr, 1'b0})));

endmodule

// File: rtl/fp_divsqrt_iter.sv
// Iterative floating-point divide / square-root unit (bit-serial mode).
// Ties the sequencer, the special-operand screen and the shared recurrence
// together, and registers the unrounded result on completion.
// Assumes normalized significands with the hidden one at bit MAN_W-1, and
// single-precision operands zero-padded in the low significand bits.
module fp_divsqrt_iter
    import dsq_pkg::*;
#(
    parameter  int MAN_W       = 53,
    parameter  int EXP_W       = 13,
    parameter  int SP_DIV_LAT  = 29,
    parameter  int SP_SQRT_LAT = 28,
    parameter  int DP_DIV_LAT  = 58,
    parameter  int DP_SQRT_LAT = 57,
    localparam int RES_W = ((DP_DIV_LAT > DP_SQRT_LAT) ? DP_DIV_LAT : DP_SQRT_LAT) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_sqrt,
    input  logic             is_dp,
    input  logic             a_sign,
    input  logic [1:0]       a_class,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [MAN_W-1:0] a_man,
    input  logic             b_sign,
    input  logic [1:0]       b_class,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [MAN_W-1:0] b_man,
    output logic             busy,
    output logic             done,
    output logic             res_sign,
    output logic [EXP_W:0]   res_exp,
    output logic [RES_W-1:0] res_man,
    output logic             res_sticky,
    output logic             res_zero,
    output logic             res_inf,
    output logic             res_nan,
    output logic             flag_nv,
    output logic             flag_dz
);

    localparam logic [RES_W-1:0] QNAN_MAN = RES_W'(1) << (RES_W - 2);

    logic             load, step, finish;
    spec_t            spec_c, spec_q;
    logic [RES_W-1:0] quo;
    logic             rem_nz;
    logic [EXP_W:0]   exp_core;

    dsq_ctrl #(
        .SP_DIV_LAT (SP_DIV_LAT),
        .SP_SQRT_LAT(SP_SQRT_LAT),
        .DP_DIV_LAT (DP_DIV_LAT),
        .DP_SQRT_LAT(DP_SQRT_LAT)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .is_sqrt(is_sqrt),
        .is_dp  (is_dp),
        .busy   (busy),
        .load   (load),
        .step   (step),
        .finish (finish),
        .done   (done)
    );

    dsq_special u_special (
        .is_sqrt(is_sqrt),
        .a_sign (a_sign),
        .a_cls  (fcls_e'(a_class)),
        .b_sign (b_sign),
        .b_cls  (fcls_e'(b_class)),
        .spec   (spec_c)
    );

    dsq_recur #(
        .MAN_W(MAN_W),
        .EXP_W(EXP_W),
        .RES_W(RES_W)
    ) u_recur (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .is_sqrt(is_sqrt),
        .a_exp  (a_exp),
        .b_exp  (b_exp),
        .a_man  (a_man),
        .b_man  (b_man),
        .quo    (quo),
        .rem_nz (rem_nz),
        .exp_res(exp_core)
    );

    // Latch the special screen at acceptance and publish results at finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spec_q     <= '0;
            res_sign   <= 1'b0;
            res_exp    <= '0;
            res_man    <= '0;
            res_sticky <= 1'b0;
            res_zero   <= 1'b0;
            res_inf    <= 1'b0;
            res_nan    <= 1'b0;
            flag_nv    <= 1'b0;
            flag_dz    <= 1'b0;
        end else begin
            if (load) spec_q <= spec_c;
            if (finish) begin
                res_sign <= spec_q.sign;
                flag_nv  <= spec_q.nv;
                flag_dz  <= spec_q.dz;
                res_zero <= spec_q.hit && (spec_q.kind == CLS_ZERO);
                res_inf  <= spec_q.hit && (spec_q.kind == CLS_INF);
                res_nan  <= spec_q.hit && (spec_q.kind == CLS_NAN);
                if (spec_q.hit) begin
                    res_exp    <= '0;
                    res_sticky <= 1'b0;
                    res_man    <= (spec_q.kind == CLS_NAN) ? QNAN_MAN : '0;
                end else begin
                    res_exp    <= exp_core;
                    res_sticky <= rem_nz;
                    res_man    <= quo;
                end
            end
        end
    end

    // R8
    nan_canonical_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_nan |-> (!res_sign && res_man == QNAN_MAN && !res_sticky && res_exp == '0));

    // R7
    dz_gives_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_dz |-> (res_inf && !flag_nv));

    // R11
    kind_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_zero, res_inf, res_nan}));

    // R12
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy && !done));

endmodule

// File: tb/test_fp_divsqrt_iter.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, mid-run restart attempts and mid-run reset.
module test_fp_divsqrt_iter;

    localparam int CLK_P = 10;
    localparam int RW    = 57;

    localparam logic [1:0] K_N = 2'd0, K_Z = 2'd1, K_I = 2'd2, K_Q = 2'd3;

    localparam logic [52:0] M_ONE  = 53'h10000000000000;
    localparam logic [52:0] M_1P5  = 53'h18000000000000;
    localparam logic [52:0] M_1P25 = 53'h14000000000000;
    localparam logic [52:0] M_MAX  = 53'h1FFFFFFFFFFFFF;
    localparam logic [52:0] M_ULP  = 53'h10000000000001;
    localparam logic [52:0] M_SP   = 53'h1B3A5C20000000;
    localparam logic [52:0] M_DP   = 53'h1A5F3C8E9D2B71;

    typedef struct packed {
        logic        sq;
        logic        dp;
        logic        as;
        logic [1:0]  ac;
        logic [12:0] ae;
        logic [52:0] am;
        logic        bs;
        logic [1:0]  bc;
        logic [12:0] be;
        logic [52:0] bm;
        logic [1:0]  ek;
        logic        es;
        logic        env;
        logic        edz;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, K_N, 13'sd3,     M_1P5, 1'b1, K_N, -13'sd2,   M_1P25, K_N, 1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, K_N, 13'sd0,     M_ONE, 1'b0, K_N, 13'sd0,    M_ONE,  K_N, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b1, K_N, 13'sd100,   M_MAX, 1'b1, K_N, -13'sd7,   M_ULP,  K_N, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b0, K_N, -13'sd5,    M_ONE, 1'b0, K_N, 13'sd4,    M_SP,   K_N, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b1, K_N, -13'sd1000, M_DP,  1'b0, K_N, 13'sd1000, M_MAX,  K_N, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b0, 1'b0, K_N, 13'sd2,     M_ONE, 1'b0, K_N, 13'sd0,    M_ONE,  K_N, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b0, 1'b0, K_N, 13'sd1,     M_ONE, 1'b0, K_N, 13'sd0,    M_ONE,  K_N, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b0, K_N, -13'sd3,    M_1P5, 1'b0, K_N, 13'sd0,    M_ONE,  K_N, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b0, K_N, 13'sd0,     M_MAX, 1'b0, K_N, 13'sd0,    M_ONE,  K_N, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b0, 1'b0, K_N, -13'sd7,    M_SP,  1'b0, K_N, 13'sd0,    M_ONE,  K_N, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b1, K_N, 13'sd0,     M_ONE, 1'b0, K_Z, 13'sd0,    M_ONE,  K_I, 1'b1, 1'b0, 1'b1},
        '{1'b0, 1'b1, 1'b0, K_Z, 13'sd0,     M_ONE, 1'b0, K_Z, 13'sd0,    M_ONE,  K_Q, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b0, 1'b0, K_I, 13'sd0,     M_ONE, 1'b1, K_I, 13'sd0,    M_ONE,  K_Q, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b1, 1'b1, K_N, 13'sd4,     M_1P5, 1'b0, K_N, 13'sd0,    M_ONE,  K_Q, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b0, 1'b1, K_Z, 13'sd0,     M_ONE, 1'b0, K_N, 13'sd0,    M_ONE,  K_Z, 1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, K_Q, 13'sd0,     M_ONE, 1'b0, K_N, 13'sd0,    M_ONE,  K_Q, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b0, K_I, 13'sd0,     M_ONE, 1'b0, K_N, 13'sd0,    M_ONE,  K_I, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b1, K_I, 13'sd0,     M_ONE, 1'b0, K_Z, 13'sd0,    M_ONE,  K_I, 1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, K_Z, 13'sd0,     M_ONE, 1'b1, K_I, 13'sd0,    M_ONE,  K_Z, 1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b0, K_N, 13'sd5,     M_SP,  1'b1, K_I, 13'sd0,    M_ONE,  K_Z, 1'b1, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          is_sqrt = 1'b0;
    logic          is_dp = 1'b0;
    logic          a_sign = 1'b0, b_sign = 1'b0;
    logic [1:0]    a_class = '0, b_class = '0;
    logic [12:0]   a_exp = '0, b_exp = '0;
    logic [52:0]   a_man = '0, b_man = '0;
    logic          busy, done, res_sign, res_sticky;
    logic [13:0]   res_exp;
    logic [RW-1:0] res_man;
    logic          res_zero, res_inf, res_nan, flag_nv, flag_dz;

    int checks = 0;
    int errors = 0;

    fp_divsqrt_iter i_fp_divsqrt_iter (
        .clk(clk), .rst_n(rst_n), .start(start), .is_sqrt(is_sqrt), .is_dp(is_dp),
        .a_sign(a_sign), .a_class(a_class), .a_exp(a_exp), .a_man(a_man),
        .b_sign(b_sign), .b_class(b_class), .b_exp(b_exp), .b_man(b_man),
        .busy(busy), .done(done), .res_sign(res_sign), .res_exp(res_exp),
        .res_man(res_man), .res_sticky(res_sticky), .res_zero(res_zero),
        .res_inf(res_inf), .res_nan(res_nan), .flag_nv(flag_nv), .flag_dz(flag_dz)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Floor square root by bisection, independent of any digit method.
    function automatic logic [127:0] isqrt(input logic [127:0] x);
        logic [127:0] lo = 0;
        logic [127:0] hi = 128'h1 << 60;
        while (hi - lo > 1) begin
            logic [127:0] mid = (lo + hi) >> 1;
            if (mid * mid <= x) lo = mid;
            else hi = mid;
        end
        return lo;
    endfunction

    // Launch one operation. Optionally poke a second start with other
    // operands on busy cycle 'poke', then check timing and results.
    task automatic run_op(input vec_t v, input int poke);
        int cycles = 0;
        bit busy_ok = 1'b1;
        int lat = v.sq ? (v.dp ? 57 : 28) : (v.dp ? 58 : 29);
        int nb = lat - 1;
        logic [127:0] x, exp_man;
        int ea, eb, exp_e;
        @(negedge clk);
        is_sqrt = v.sq; is_dp = v.dp;
        a_sign = v.as; a_class = v.ac; a_exp = v.ae; a_man = v.am;
        b_sign = v.bs; b_class = v.bc; b_exp = v.be; b_man = v.bm;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cycles < 200) begin
            if (!busy) busy_ok = 1'b0;
            @(negedge clk);
            cycles++;
            if (poke != 0 && cycles == poke) begin
                start = 1'b1; is_sqrt = ~v.sq; is_dp = 1'b1;
                a_man = M_DP; a_exp = 13'sd9; b_class = K_Z; b_man = M_MAX;
            end
            if (poke != 0 && cycles == poke + 1) start = 1'b0;
        end
        check(cycles == lat, "R1", "latency", 128'(cycles), 128'(lat));
        check(busy_ok && !busy, "R2", "busy window", {busy_ok, busy}, 2'b10);
        ea = int'($signed(v.ae));
        eb = int'($signed(v.be));
        if (v.ek == K_N) begin
            if (v.sq) begin
                x = (v.ae[0] ? (128'(v.am) << 1) : 128'(v.am)) << (2 * nb - 54);
                exp_man = isqrt(x);
                check(128'(res_man) == exp_man, "R5", "root", 128'(res_man), exp_man);
                check(res_sticky == (x != exp_man * exp_man), "R6", "sticky",
                      128'(res_sticky), 128'(x != exp_man * exp_man));
                exp_e = ea >>> 1;
                check(int'($signed(res_exp)) == exp_e, "R5", "exponent",
                      128'(res_exp), 128'(exp_e));
            end else begin
                x = 128'(v.am) << (nb - 1);
                exp_man = x / 128'(v.bm);
                check(128'(res_man) == exp_man, "R4", "quotient", 128'(res_man), exp_man);
                check(res_sticky == ((x % 128'(v.bm)) != 0), "R6", "sticky",
                      128'(res_sticky), 128'((x % 128'(v.bm)) != 0));
                exp_e = ea - eb;
                check(int'($signed(res_exp)) == exp_e, "R4", "exponent",
                      128'(res_exp), 128'(exp_e));
            end
            check(res_sign == v.es && !flag_nv && !flag_dz && !res_zero && !res_inf && !res_nan,
                  v.sq ? "R5" : "R4", "sign/flags",
                  {res_sign, flag_nv, flag_dz, res_zero, res_inf, res_nan}, {v.es, 5'b0});
        end else begin
            exp_man = (v.ek == K_Q) ? (128'h1 << 55) : 128'h0;
            check({res_zero, res_inf, res_nan} == {v.ek == K_Z, v.ek == K_I, v.ek == K_Q},
                  "R11", "result kind", {res_zero, res_inf, res_nan},
                  {v.ek == K_Z, v.ek == K_I, v.ek == K_Q});
            check(flag_nv == v.env && flag_dz == v.edz, v.env ? "R8" : "R7", "flags",
                  {flag_nv, flag_dz}, {v.env, v.edz});
            check(res_sign == v.es && 128'(res_man) == exp_man && res_exp == '0 && !res_sticky,
                  (v.ek == K_Q) ? "R9" : "R10", "special payload",
                  {res_sign, res_sticky, res_exp, res_man}, {v.es, 1'b0, 14'h0, exp_man[56:0]});
        end
        @(negedge clk);
        check(!done, "R2", "done pulse width", 128'(done), 128'(0));
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(CLK_P * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int extra;
        repeat (3) @(negedge clk);
        // R12: reset state
        check(!busy && !done && !flag_nv && !flag_dz && !res_nan && !res_inf && !res_zero,
              "R12", "reset outputs", {busy, done, flag_nv, flag_dz, res_nan, res_inf, res_zero}, 0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) run_op(VECS[k], 0);

        // R3: start and new operands while busy are ignored
        run_op(VECS[0], 5);
        extra = 0;
        repeat (80) begin
            @(negedge clk);
            if (done || busy) extra++;
        end
        check(extra == 0, "R3", "no second run", 128'(extra), 128'(0));

        // R12: reset during a run cancels it
        @(negedge clk);
        is_sqrt = 1'b0; is_dp = 1'b1; a_class = K_N; b_class = K_N;
        a_man = M_MAX; b_man = M_ULP; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(!busy && !done && !res_nan && !flag_nv, "R12", "mid-run reset",
              {busy, done, res_nan, flag_nv}, 0);
        extra = 0;
        repeat (80) begin
            @(negedge clk);
            if (done) extra++;
        end
        check(extra == 0, "R12", "cancelled run silent", 128'(extra), 128'(0));
        run_op(VECS[6], 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule